// File: doc/BRIEF.md
# Capability Trap and PCC Swap Controller

This block handles faults raised by the capability coprocessor of a processor that uses capabilities. A fault request carries a cause index and, when one applies, the number of the capability register that caused it. In one clock edge the block does four things. It writes a 16-bit cause register holding an 8-bit cause code and an 8-bit register field. It reports which trap class to raise. It saves the current program-counter capability (PCC) as the exception PCC, with the offset field replaced by the faulting PC. It installs the kernel code capability as both the next PCC and the delayed PCC. It also passes on the base of the kernel code capability as the vector base for the general exception logic.

An exception-return request copies the saved exception PCC back into the next PCC and the delayed PCC. A separate combinational port tells the decoder whether a capability register index is privileged under the current PCC.

Capabilities are flat vectors. The offset field, the base field and the system-register permission bit sit at positions set by parameters.

Top module: `cap_trap_ctrl`

## Requirements
- R1: After reset, the cause register, the exception PCC, the next PCC and the delayed PCC are all zero, and `trap_valid_o` is low.
- R2: A fault with cause index 0 to 10 writes the index itself (0x00 to 0x0A) into cause bits 15:8. The index order is: none, length, tag, seal, type, call trap, return trap, trusted-stack underflow, user-defined, TLB no-store-cap, inexact bounds.
- R3: A fault with cause index 11 to 19 writes 0x10 to 0x18 into cause bits 15:8, which is the index plus 5. The index order is: global, execute, load, store, load-cap, store-cap, store-local-cap, seal permission, system-register access.
- R4: Cause bits 7:0 hold the 5-bit register index, zero-extended, when `fault_has_reg_i` is high. When it is low they hold 0xFF.
- R5: `trap_class_o` is 1 (capability trap) for cause indices 5 and 6 and 0 (capability error) for every other cause. It is updated on each fault.
- R6: On a fault, the exception PCC takes the value of `pcc_i` with its offset field (bits OFF_LSB+XLEN-1:OFF_LSB) replaced by `pc_i`. All other bits are kept.
- R7: On a fault, the next PCC and the delayed PCC both take `kcc_i`, and `vector_base_o` takes the base field of `kcc_i` (bits BASE_LSB+XLEN-1:BASE_LSB).
- R8: An exception return with no fault copies the exception PCC into both the next PCC and the delayed PCC. It leaves the cause register and the exception PCC unchanged.
- R9: When a fault and an exception return arrive in the same cycle, the fault is taken and the return is ignored.
- R10: `reg_locked_o` is high exactly when `chk_reg_i` is 27 to 31 and bit SYS_BIT of `pcc_i` is clear. Registers 0 to 26 are never locked.
- R11: `trap_valid_o` is high for exactly the one cycle after each fault. In cycles with no fault, the cause register and the exception PCC hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 1 | Fault request |
| fault_cause_i | input | 5 | Cause index, 0 to 19 |
| fault_has_reg_i | input | 1 | The fault names a register |
| fault_reg_i | input | 5 | Faulting capability register index |
| eret_i | input | 1 | Exception return request |
| pc_i | input | XLEN | Faulting PC |
| pcc_i | input | CAP_W | Current program-counter capability |
| kcc_i | input | CAP_W | Kernel code capability |
| chk_reg_i | input | 5 | Register index to test for privilege |
| reg_locked_o | output | 1 | The tested register is inaccessible |
| trap_valid_o | output | 1 | A fault was taken last cycle |
| trap_class_o | output | 1 | 1 = capability trap, 0 = capability error |
| cause_o | output | 16 | Cause register: code in 15:8, register in 7:0 |
| vector_base_o | output | XLEN | Kernel code capability base for vectoring |
| epcc_o | output | CAP_W | Exception PCC |
| next_pcc_o | output | CAP_W | Next PCC |
| delayed_pcc_o | output | CAP_W | Delayed PCC |

## Verification
The assertions assume that `fault_cause_i` never exceeds 19 while `fault_i` is high, since higher indices have no defined code. Every table entry and directed fault in the bench uses an index between 0 and 19. They also assume that the register inputs are stable across each edge. The bench drives all inputs on the falling edge, so this holds. The bench puts both ends of each cause range into its table and mixes faults that carry a register with faults that do not. It checks the case where a fault and a return arrive together. It also changes `kcc_i` before a return, so that a value still tracking the kernel capability would show up at the outputs.

// File: rtl/cap_trap_ctrl.sv
module cap_trap_ctrl #(
  parameter int CAP_W    = 257,
  parameter int XLEN     = 64,
  parameter int OFF_LSB  = 128,
  parameter int BASE_LSB = 64,
  parameter int SYS_BIT  = 203,
  parameter int RIDX_W   = 5,
  parameter int PRIV_LO  = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  logic [4:0]        fault_cause_i,
  input  logic              fault_has_reg_i,
  input  logic [RIDX_W-1:0] fault_reg_i,
  input  logic              eret_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [CAP_W-1:0]  pcc_i,
  input  logic [CAP_W-1:0]  kcc_i,
  input  logic [RIDX_W-1:0] chk_reg_i,
  output logic              reg_locked_o,
  output logic              trap_valid_o,
  output logic              trap_class_o,
  output logic [15:0]       cause_o,
  output logic [XLEN-1:0]   vector_base_o,
  output logic [CAP_W-1:0]  epcc_o,
  output logic [CAP_W-1:0]  next_pcc_o,
  output logic [CAP_W-1:0]  delayed_pcc_o
);

  localparam int          OFF_HI    = OFF_LSB + XLEN - 1;
  localparam int          BASE_HI   = BASE_LSB + XLEN - 1;
  localparam logic [4:0]  LAST_PLAIN = 5'd10;
  localparam logic [4:0]  CALL_IDX  = 5'd5;
  localparam logic [4:0]  RET_IDX   = 5'd6;
  localparam logic [7:0]  NO_REG    = 8'hFF;
  localparam logic [RIDX_W-1:0] PRIV_FIRST = RIDX_W'(PRIV_LO);

  logic [7:0]       code_w;
  logic [7:0]       regf_w;
  logic [CAP_W-1:0] saved_w;

  assign code_w = (fault_cause_i <= LAST_PLAIN) ? {3'b000, fault_cause_i}
                                                : {3'b000, fault_cause_i} + 8'd5;
  assign regf_w = fault_has_reg_i ? 8'(fault_reg_i) : NO_REG;

  always_comb begin
    saved_w = pcc_i;
    saved_w[OFF_HI:OFF_LSB] = pc_i;
  end

  assign reg_locked_o = (chk_reg_i >= PRIV_FIRST) && !pcc_i[SYS_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_o       <= '0;
      trap_valid_o  <= 1'b0;
      trap_class_o  <= 1'b0;
      vector_base_o <= '0;
      epcc_o        <= '0;
      next_pcc_o    <= '0;
      delayed_pcc_o <= '0;
    end else begin
      trap_valid_o <= fault_i;
      if (fault_i) begin
        cause_o       <= {code_w, regf_w};
        trap_class_o  <= (fault_cause_i == CALL_IDX) || (fault_cause_i == RET_IDX);
        vector_base_o <= kcc_i[BASE_HI:BASE_LSB];
        epcc_o        <= saved_w;
        next_pcc_o    <= kcc_i;
        delayed_pcc_o <= kcc_i;
      end else if (eret_i) begin
        next_pcc_o    <= epcc_o;
        delayed_pcc_o <= epcc_o;
      end
    end
  end

  // R7 R9
  kcc_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (next_pcc_o == $past(kcc_i)) && (delayed_pcc_o == $past(kcc_i)));

  // R6
  pc_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> epcc_o[OFF_HI:OFF_LSB] == $past(pc_i));

  // R8
  eret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !fault_i) |=> (next_pcc_o == $past(epcc_o)) && (delayed_pcc_o == $past(epcc_o)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> $stable(cause_o) && $stable(epcc_o) && !trap_valid_o);

  // R5
  trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid_o && trap_class_o) |-> (cause_o[15:8] == 8'h05 || cause_o[15:8] == 8'h06));

  // R10
  low_reg_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_reg_i < PRIV_FIRST) |-> !reg_locked_o);

  // R2 R3
  cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |-> fault_cause_i <= 5'd19);

endmodule

// File: tb/cap_trap_ctrl_tb.sv
module cap_trap_ctrl_tb;
  localparam int CAP_W = 257;
  localparam int XLEN  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault = 1'b0, has_reg = 1'b0, eret = 1'b0;
  logic [4:0] cause = '0, freg = '0, chk = '0;
  logic [XLEN-1:0] pc = '0;
  logic [CAP_W-1:0] pcc = '0, kcc = '0;
  logic locked, tvalid, tclass;
  logic [15:0] cause_q;
  logic [XLEN-1:0] vbase;
  logic [CAP_W-1:0] epcc, npcc, dpcc;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cap_trap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault), .fault_cause_i(cause),
    .fault_has_reg_i(has_reg), .fault_reg_i(freg), .eret_i(eret), .pc_i(pc),
    .pcc_i(pcc), .kcc_i(kcc), .chk_reg_i(chk), .reg_locked_o(locked),
    .trap_valid_o(tvalid), .trap_class_o(tclass), .cause_o(cause_q),
    .vector_base_o(vbase), .epcc_o(epcc), .next_pcc_o(npcc), .delayed_pcc_o(dpcc));

  // {cause idx[27:23], has_reg[22], reg[21:17], expected cause[16:1], expected class[0]}
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {5'd0,  1'b0, 5'd3,  16'h00FF, 1'b0},
    {5'd1,  1'b1, 5'd7,  16'h0107, 1'b0},
    {5'd5,  1'b1, 5'd31, 16'h051F, 1'b1},
    {5'd6,  1'b0, 5'd0,  16'h06FF, 1'b1},
    {5'd7,  1'b1, 5'd0,  16'h0700, 1'b0},
    {5'd10, 1'b1, 5'd26, 16'h0A1A, 1'b0},
    {5'd11, 1'b0, 5'd9,  16'h10FF, 1'b0},
    {5'd14, 1'b1, 5'd12, 16'h130C, 1'b0},
    {5'd19, 1'b1, 5'd29, 16'h181D, 1'b0},
    {5'd4,  1'b0, 5'd31, 16'h04FF, 1'b0}
  };

  task automatic chk_val(input string req, input logic [CAP_W-1:0] act, input logic [CAP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CAP_W-1:0] mk_cap(input logic sys, input logic [63:0] off,
                                               input logic [63:0] base, input logic [63:0] len);
    logic [CAP_W-1:0] c;
    c = '0;
    c[256] = 1'b1;
    c[203] = sys;
    c[195] = 1'b1;
    c[191:128] = off;
    c[127:64] = base;
    c[63:0] = len;
    return c;
  endfunction

  initial begin
    logic [CAP_W-1:0] exp_epcc, k1, k2;
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [CAP_W-1:0] exp_e, k1, k2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_val("R1 cause", cause_q, 0);
    chk_val("R1 epcc", epcc, 0);
    chk_val("R1 next", npcc, 0);
    chk_val("R1 delayed", dpcc, 0);
    chk_val("R1 valid", tvalid, 0);

    // R2 R3 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      fault = 1'b1; cause = VEC[i][27:23]; has_reg = VEC[i][22]; freg = VEC[i][21:17];
      @(negedge clk);
      fault = 1'b0;
      chk_val("R2/R3/R4 cause", cause_q, VEC[i][16:1]);
      chk_val("R5 class", tclass, VEC[i][0]);
      chk_val("R11 valid pulse", tvalid, 1);
    end
    @(negedge clk);
    // R11 idle hold
    chk_val("R11 valid drop", tvalid, 0);
    chk_val("R11 cause hold", cause_q, 16'h04FF);

    // R6 R7 swap
    pcc = mk_cap(1'b1, 64'h1111, 64'h4000_0000, 64'h10000);
    pc  = 64'hDEAD_BEE0;
    k1  = mk_cap(1'b1, 64'h0, 64'h9000_0000_0000_0180, 64'hFFFF);
    kcc = k1;
    exp_e = pcc; exp_e[191:128] = pc;
    fault = 1'b1; cause = 5'd2; has_reg = 1'b1; freg = 5'd4;
    @(negedge clk);
    fault = 1'b0;
    chk_val("R6 epcc", epcc, exp_e);
    chk_val("R7 next", npcc, k1);
    chk_val("R7 delayed", dpcc, k1);
    chk_val("R7 vector", vbase, 64'h9000_0000_0000_0180);

    // R8 eret restore, with kcc changed
    kcc = mk_cap(1'b0, 64'h5, 64'h77, 64'h88);
    pc = 64'h0;
    eret = 1'b1;
    @(negedge clk);
    eret = 1'b0;
    chk_val("R8 next", npcc, exp_e);
    chk_val("R8 delayed", dpcc, exp_e);
    chk_val("R8 epcc unchanged", epcc, exp_e);
    chk_val("R8 cause unchanged", cause_q, 16'h0204);

    // R9 fault beats eret
    k2 = mk_cap(1'b0, 64'h0, 64'hABC0, 64'h40);
    kcc = k2;
    pc = 64'h2468;
    fault = 1'b1; eret = 1'b1; cause = 5'd6; has_reg = 1'b0;
    @(negedge clk);
    fault = 1'b0; eret = 1'b0;
    chk_val("R9 next", npcc, k2);
    chk_val("R9 delayed", dpcc, k2);
    chk_val("R9 cause", cause_q, 16'h06FF);
    chk_val("R9 class", tclass, 1);

    // R10 privilege check
    for (int s = 0; s < 2; s++) begin
      pcc = mk_cap(s[0], 64'h0, 64'h0, 64'h0);
      for (int r = 0; r < 32; r++) begin
        chk = r[4:0];
        #1;
        chk_val("R10 locked", locked, (r >= 27) && (s == 0));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule